// File: doc/BRIEF.md
# Im2col Tile Address Generator

The block feeds a matrix engine with one tile of the unrolled ("im2col") convolution input matrix. Row x of that matrix stands for a filter tap (c, r, s) and column y stands for an output position (n, p, q). For every element of the requested tile the block works out where the matching input pixel sits in a feature-map buffer stored batch-major, then channel, then row, then column. It issues that linear address on a read port and passes on the 16-bit pixel that comes back.

A run starts with a one-cycle `start` pulse. The layer shape, the tile origin and the tile size are presented with it. The origin row and column indices are split into their three parts with subtract-and-count stepping, so no general divider is needed. The block then walks carry-chained counters over up to `TILE` consecutive rows and columns. It stores one partial address per tile row and one per tile column. Each element address is then just one row term plus one column term. The index work therefore grows with the tile edge, not with the tile area. Elements are emitted one per cycle in 4×4 sub-tile order. Positions that fall past the matrix edge are never emitted.

The layer configuration inputs must stay stable from `start` until `done`. The tile sizes are 1 to `TILE`. Both origins must lie inside the matrix. All radices (R, S, P, Q) must be at least 1.

Top module: `im2col_addr_gen`

## Requirements
- R1: For tile row i and tile column j, the block uses x = org_x + i and y = org_y + j. It takes c = x / (R·S), r = (x mod R·S) / S, s = x mod S, n = y / (P·Q), p = (y mod P·Q) / Q and q = y mod Q. The emitted address is ((n·C + c)·H + p·u + r)·W + q·v + s.
- R2: `out_row` and `out_col` give the element's position relative to the tile origin, as i and j.
- R3: The block emits exactly eh·ew elements and none outside that range. Here eh = min(tile_h, C·R·S − org_x) and ew = min(tile_w, N·P·Q − org_y).
- R4: Emission order runs over 4×4 sub-tiles. Sub-tile rows go top to bottom, and within a sub-tile row the sub-tiles go left to right. Inside a sub-tile the order is row-major. Sub-tiles at the clipped edge shrink to the valid part.
- R5: Once emission begins, `out_valid` stays high on consecutive cycles until the final element.
- R6: `done` is high for exactly one cycle, in the cycle after the final `out_valid` beat, and never together with `out_valid`.
- R7: `mem_rd` and `mem_addr` follow `out_valid` and `out_addr`. One cycle later `pix_valid`, `pix_row` and `pix_col` repeat the beat, and `pix_data` carries the read data of a one-cycle-latency synchronous memory.
- R8: A `start` pulse that arrives while `busy` is high is ignored. The running tile completes with its original origin.
- R9: After reset `busy`, `done`, `out_valid`, `mem_rd` and `pix_valid` are low.
- R10: Across consecutive tile rows, s counts up to S−1 and carries into r, and r carries into c. Across consecutive columns, q carries into p and p carries into n. Every decomposed index stays below its radix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a tile (taken only when idle) |
| cfg_n | input | DIM_W | Batch size N |
| cfg_c | input | DIM_W | Input channels C |
| cfg_h | input | DIM_W | Feature-map height H |
| cfg_w | input | DIM_W | Feature-map width W |
| cfg_r | input | DIM_W | Filter height R |
| cfg_s | input | DIM_W | Filter width S |
| cfg_p | input | DIM_W | Output height P |
| cfg_q | input | DIM_W | Output width Q |
| cfg_u | input | DIM_W | Vertical stride u |
| cfg_v | input | DIM_W | Horizontal stride v |
| org_x | input | IDX_W | Tile origin row in the unrolled matrix |
| org_y | input | IDX_W | Tile origin column in the unrolled matrix |
| tile_h | input | $clog2(TILE)+1 | Tile height, 1..TILE |
| tile_w | input | $clog2(TILE)+1 | Tile width, 1..TILE |
| busy | output | 1 | Tile in progress |
| done | output | 1 | One-cycle end-of-tile pulse |
| out_valid | output | 1 | Address beat valid |
| out_row | output | $clog2(TILE) | Tile-relative row of the beat |
| out_col | output | $clog2(TILE) | Tile-relative column of the beat |
| out_addr | output | ADDR_W | Linear source-pixel address |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | PIX_W | Memory read data, one cycle after `mem_rd` |
| pix_valid | output | 1 | Pixel beat valid |
| pix_row | output | $clog2(TILE) | Tile-relative row of the pixel |
| pix_col | output | $clog2(TILE) | Tile-relative column of the pixel |
| pix_data | output | PIX_W | Fetched 16-bit pixel |

## Verification
The bench keeps the default build: TILE = 16, 4×4 sub-tiles, 12-bit matrix indices and 20-bit addresses. It pairs this with small random layer shapes (up to 3 channels, 7×7 maps, 3×3 filters, strides of 1 or 2, batch of 2). With these shapes a 16-wide tile routinely crosses s→r→c and q→p→n carries. The shapes also put the unrolled matrix edge inside the tile, so one-wide and partial sub-tiles occur. Directed tiles cover a full-height clip, a tile clipped on both edges, the single final element, and a start pulse sent mid-run.

// File: rtl/im2col_pkg.sv
package im2col_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SPLIT,
    ST_BUILD,
    ST_EMIT,
    ST_TAIL,
    ST_DONE
  } phase_e;

  // Weighted sum of a three-level index: outer*ko + mid*km + inner*ki.
  function automatic logic [31:0] lin_term(input logic [31:0] o, input logic [31:0] m,
                                           input logic [31:0] i, input logic [31:0] ko,
                                           input logic [31:0] km, input logic [31:0] ki);
    return o * ko + m * km + i * ki;
  endfunction

  // Length of a tile edge after clipping at the matrix boundary.
  function automatic logic [31:0] clip_len(input logic [31:0] origin, input logic [31:0] len,
                                           input logic [31:0] total);
    logic [31:0] room;
    room = total - origin;
    return (room < len) ? room : len;
  endfunction

endpackage

// File: rtl/im2col_split.sv
// Splits an index into (outer, mid, inner) for radices (mid_rad, in_rad)
// by subtracting whole blocks, then whole inner spans.
module im2col_split #(
  parameter int IDX_W = 12,
  parameter int DIM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [IDX_W-1:0] value,
  input  logic [DIM_W-1:0] rad_mid,
  input  logic [DIM_W-1:0] rad_in,
  output logic [IDX_W-1:0] outer,
  output logic [DIM_W-1:0] mid,
  output logic [DIM_W-1:0] inner,
  output logic             ready
);
  logic [IDX_W-1:0] rem;
  logic [IDX_W-1:0] blk;
  logic [IDX_W-1:0] span;
  logic             running;

  assign blk  = IDX_W'(rad_mid) * IDX_W'(rad_in);
  assign span = IDX_W'(rad_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem     <= '0;
      outer   <= '0;
      mid     <= '0;
      inner   <= '0;
      ready   <= 1'b0;
      running <= 1'b0;
    end else if (start) begin
      rem     <= value;
      outer   <= '0;
      mid     <= '0;
      inner   <= '0;
      ready   <= 1'b0;
      running <= 1'b1;
    end else if (running) begin
      if (rem >= blk) begin
        outer <= outer + 1'b1;
        rem   <= rem - blk;
      end else if (rem >= span) begin
        mid <= mid + 1'b1;
        rem <= rem - span;
      end else begin
        inner   <= DIM_W'(rem);
        running <= 1'b0;
        ready   <= 1'b1;
      end
    end
  end

  // R10
  split_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (mid < rad_mid) && (inner < rad_in));

endmodule

// File: rtl/im2col_axis.sv
// Walks TILE consecutive indices from a decomposed start point with a
// carry chain inner -> mid -> outer and stores one partial address each.
module im2col_axis #(
  parameter int TILE   = 16,
  parameter int IDX_W  = 12,
  parameter int DIM_W  = 8,
  parameter int ADDR_W = 20,
  localparam int POS_W = $clog2(TILE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [IDX_W-1:0]  st_o,
  input  logic [DIM_W-1:0]  st_m,
  input  logic [DIM_W-1:0]  st_i,
  input  logic [DIM_W-1:0]  rad_m,
  input  logic [DIM_W-1:0]  rad_i,
  input  logic [ADDR_W-1:0] k_o,
  input  logic [ADDR_W-1:0] k_m,
  input  logic [ADDR_W-1:0] k_i,
  output logic              filled,
  input  logic [POS_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_term
);
  import im2col_pkg::*;

  localparam logic [POS_W:0] LAST_K = (POS_W+1)'(TILE - 1);

  logic [IDX_W-1:0]  o_cnt;
  logic [DIM_W-1:0]  m_cnt;
  logic [DIM_W-1:0]  i_cnt;
  logic [POS_W:0]    k;
  logic              busy;
  logic [ADDR_W-1:0] tab [TILE];
  logic [ADDR_W-1:0] term_now;
  logic              wrap_i;
  logic              wrap_m;

  assign term_now = ADDR_W'(lin_term(32'(o_cnt), 32'(m_cnt), 32'(i_cnt),
                                     32'(k_o), 32'(k_m), 32'(k_i)));
  assign wrap_i = (i_cnt + 1'b1) == rad_i;
  assign wrap_m = (m_cnt + 1'b1) == rad_m;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_cnt  <= '0;
      m_cnt  <= '0;
      i_cnt  <= '0;
      k      <= '0;
      busy   <= 1'b0;
      filled <= 1'b0;
    end else begin
      filled <= busy && (k == LAST_K);
      if (load) begin
        o_cnt <= st_o;
        m_cnt <= st_m;
        i_cnt <= st_i;
        k     <= '0;
        busy  <= 1'b1;
      end else if (busy) begin
        k <= k + 1'b1;
        if (k == LAST_K) busy <= 1'b0;
        if (wrap_i) begin
          i_cnt <= '0;
          if (wrap_m) begin
            m_cnt <= '0;
            o_cnt <= o_cnt + 1'b1;
          end else begin
            m_cnt <= m_cnt + 1'b1;
          end
        end else begin
          i_cnt <= i_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (busy) tab[k[POS_W-1:0]] <= term_now;
  end

  assign rd_term = tab[rd_idx];

  // R10
  walk_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (i_cnt < rad_i) && (m_cnt < rad_m));

endmodule

// File: rtl/im2col_seq.sv
// Visits the clipped eff_h x eff_w region in SUB x SUB sub-tile order.
module im2col_seq #(
  parameter int TILE  = 16,
  parameter int SUB   = 4,
  localparam int CNT_W = $clog2(TILE + SUB) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CNT_W-1:0] eff_h,
  input  logic [CNT_W-1:0] eff_w,
  output logic             valid,
  output logic             last,
  output logic [CNT_W-1:0] row,
  output logic [CNT_W-1:0] col
);
  localparam logic [CNT_W-1:0] SUB_C = CNT_W'(SUB);

  logic [CNT_W-1:0] sr, sc, ir, jc;
  logic [CNT_W-1:0] room_h, room_w, lim_h, lim_w;
  logic             end_j, end_i, end_sc, end_sr;

  assign room_h = eff_h - sr;
  assign room_w = eff_w - sc;
  assign lim_h  = (room_h < SUB_C) ? room_h : SUB_C;
  assign lim_w  = (room_w < SUB_C) ? room_w : SUB_C;
  assign end_j  = (jc + 1'b1) >= lim_w;
  assign end_i  = (ir + 1'b1) >= lim_h;
  assign end_sc = (sc + SUB_C) >= eff_w;
  assign end_sr = (sr + SUB_C) >= eff_h;
  assign last   = end_j && end_i && end_sc && end_sr;
  assign row    = sr + ir;
  assign col    = sc + jc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      sr <= '0; sc <= '0; ir <= '0; jc <= '0;
    end else if (go) begin
      valid <= 1'b1;
      sr <= '0; sc <= '0; ir <= '0; jc <= '0;
    end else if (valid) begin
      if (last) begin
        valid <= 1'b0;
      end else if (!end_j) begin
        jc <= jc + 1'b1;
      end else begin
        jc <= '0;
        if (!end_i) begin
          ir <= ir + 1'b1;
        end else begin
          ir <= '0;
          if (!end_sc) begin
            sc <= sc + SUB_C;
          end else begin
            sc <= '0;
            sr <= sr + SUB_C;
          end
        end
      end
    end
  end

  // R5
  seq_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !last && !go) |=> valid);

  // R3
  seq_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> (row < eff_h) && (col < eff_w));

endmodule

// File: rtl/im2col_addr_gen.sv
module im2col_addr_gen #(
  parameter int TILE   = 16,
  parameter int SUB    = 4,
  parameter int DIM_W  = 8,
  parameter int IDX_W  = 12,
  parameter int ADDR_W = 20,
  parameter int PIX_W  = 16,
  localparam int POS_W = $clog2(TILE),
  localparam int LEN_W = $clog2(TILE) + 1,
  localparam int CNT_W = $clog2(TILE + SUB) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DIM_W-1:0]  cfg_n,
  input  logic [DIM_W-1:0]  cfg_c,
  input  logic [DIM_W-1:0]  cfg_h,
  input  logic [DIM_W-1:0]  cfg_w,
  input  logic [DIM_W-1:0]  cfg_r,
  input  logic [DIM_W-1:0]  cfg_s,
  input  logic [DIM_W-1:0]  cfg_p,
  input  logic [DIM_W-1:0]  cfg_q,
  input  logic [DIM_W-1:0]  cfg_u,
  input  logic [DIM_W-1:0]  cfg_v,
  input  logic [IDX_W-1:0]  org_x,
  input  logic [IDX_W-1:0]  org_y,
  input  logic [LEN_W-1:0]  tile_h,
  input  logic [LEN_W-1:0]  tile_w,
  output logic              busy,
  output logic              done,
  output logic              out_valid,
  output logic [POS_W-1:0]  out_row,
  output logic [POS_W-1:0]  out_col,
  output logic [ADDR_W-1:0] out_addr,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [PIX_W-1:0]  mem_rdata,
  output logic              pix_valid,
  output logic [POS_W-1:0]  pix_row,
  output logic [POS_W-1:0]  pix_col,
  output logic [PIX_W-1:0]  pix_data
);
  import im2col_pkg::*;

  phase_e state;

  logic             accept;
  logic [IDX_W-1:0] rows_total, cols_total;
  logic [CNT_W-1:0] eff_h_q, eff_w_q;

  // row strides: c -> H*W, r -> W, s -> 1; column strides: n -> C*H*W, p -> u*W, q -> v
  logic [ADDR_W-1:0] rk_o, rk_m, rk_i, ck_o, ck_m, ck_i;

  logic [IDX_W-1:0] rs_o, cs_o;
  logic [DIM_W-1:0] rs_m, rs_i, cs_m, cs_i;
  logic             rs_rdy, cs_rdy;
  logic             tab_load;
  logic             row_filled, col_filled;
  logic             seq_go, seq_valid, seq_last;
  logic [CNT_W-1:0] seq_row, seq_col;
  logic [ADDR_W-1:0] row_term, col_term;

  assign accept     = start && (state == ST_IDLE);
  assign rows_total = IDX_W'(cfg_c) * IDX_W'(cfg_r) * IDX_W'(cfg_s);
  assign cols_total = IDX_W'(cfg_n) * IDX_W'(cfg_p) * IDX_W'(cfg_q);

  assign rk_o = ADDR_W'(cfg_h) * ADDR_W'(cfg_w);
  assign rk_m = ADDR_W'(cfg_w);
  assign rk_i = ADDR_W'(1);
  assign ck_o = ADDR_W'(cfg_c) * rk_o;
  assign ck_m = ADDR_W'(cfg_u) * ADDR_W'(cfg_w);
  assign ck_i = ADDR_W'(cfg_v);

  assign tab_load = (state == ST_SPLIT) && rs_rdy && cs_rdy;
  assign seq_go   = (state == ST_BUILD) && row_filled;

  im2col_split #(.IDX_W(IDX_W), .DIM_W(DIM_W)) u_row_split (
    .clk(clk), .rst_n(rst_n), .start(accept), .value(org_x),
    .rad_mid(cfg_r), .rad_in(cfg_s),
    .outer(rs_o), .mid(rs_m), .inner(rs_i), .ready(rs_rdy)
  );

  im2col_split #(.IDX_W(IDX_W), .DIM_W(DIM_W)) u_col_split (
    .clk(clk), .rst_n(rst_n), .start(accept), .value(org_y),
    .rad_mid(cfg_p), .rad_in(cfg_q),
    .outer(cs_o), .mid(cs_m), .inner(cs_i), .ready(cs_rdy)
  );

  im2col_axis #(.TILE(TILE), .IDX_W(IDX_W), .DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_row_axis (
    .clk(clk), .rst_n(rst_n), .load(tab_load),
    .st_o(rs_o), .st_m(rs_m), .st_i(rs_i), .rad_m(cfg_r), .rad_i(cfg_s),
    .k_o(rk_o), .k_m(rk_m), .k_i(rk_i), .filled(row_filled),
    .rd_idx(POS_W'(seq_row)), .rd_term(row_term)
  );

  im2col_axis #(.TILE(TILE), .IDX_W(IDX_W), .DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_col_axis (
    .clk(clk), .rst_n(rst_n), .load(tab_load),
    .st_o(cs_o), .st_m(cs_m), .st_i(cs_i), .rad_m(cfg_p), .rad_i(cfg_q),
    .k_o(ck_o), .k_m(ck_m), .k_i(ck_i), .filled(col_filled),
    .rd_idx(POS_W'(seq_col)), .rd_term(col_term)
  );

  im2col_seq #(.TILE(TILE), .SUB(SUB)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(seq_go), .eff_h(eff_h_q), .eff_w(eff_w_q),
    .valid(seq_valid), .last(seq_last), .row(seq_row), .col(seq_col)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      eff_h_q <= '0;
      eff_w_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          eff_h_q <= CNT_W'(clip_len(32'(org_x), 32'(tile_h), 32'(rows_total)));
          eff_w_q <= CNT_W'(clip_len(32'(org_y), 32'(tile_w), 32'(cols_total)));
          state   <= ST_SPLIT;
        end
        ST_SPLIT: if (tab_load) state <= ST_BUILD;
        ST_BUILD: if (seq_go) state <= ST_EMIT;
        ST_EMIT:  if (seq_valid && seq_last) state <= ST_TAIL;
        ST_TAIL:  state <= ST_DONE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_row   <= '0;
      out_col   <= '0;
      out_addr  <= '0;
      pix_valid <= 1'b0;
      pix_row   <= '0;
      pix_col   <= '0;
    end else begin
      out_valid <= seq_valid;
      out_row   <= POS_W'(seq_row);
      out_col   <= POS_W'(seq_col);
      out_addr  <= row_term + col_term;
      pix_valid <= out_valid;
      pix_row   <= out_row;
      pix_col   <= out_col;
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_DONE);
  assign mem_rd   = out_valid;
  assign mem_addr = out_addr;
  assign pix_data = mem_rdata;

  // R6
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid) && !out_valid);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R5
  emit_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_valid |-> (state == ST_EMIT));

  // R8
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy && !done) |=> busy);

  // R10
  axes_in_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    row_filled == col_filled);

endmodule

// File: tb/im2col_addr_gen_test.sv
`timescale 1ns/1ps
module im2col_addr_gen_test;
  localparam int TILE = 16, SUB = 4, DIM_W = 8, IDX_W = 12, ADDR_W = 20, PIX_W = 16;
  localparam int POS_W = $clog2(TILE), LEN_W = $clog2(TILE) + 1;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, start;
  logic [DIM_W-1:0] cfg_n, cfg_c, cfg_h, cfg_w, cfg_r, cfg_s, cfg_p, cfg_q, cfg_u, cfg_v;
  logic [IDX_W-1:0] org_x, org_y;
  logic [LEN_W-1:0] tile_h, tile_w;
  logic busy, done, out_valid, mem_rd, pix_valid;
  logic [POS_W-1:0] out_row, out_col, pix_row, pix_col;
  logic [ADDR_W-1:0] out_addr, mem_addr;
  logic [PIX_W-1:0] mem_rdata, pix_data;

  im2col_addr_gen #(.TILE(TILE), .SUB(SUB), .DIM_W(DIM_W), .IDX_W(IDX_W),
                    .ADDR_W(ADDR_W), .PIX_W(PIX_W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_n(cfg_n), .cfg_c(cfg_c), .cfg_h(cfg_h), .cfg_w(cfg_w), .cfg_r(cfg_r),
    .cfg_s(cfg_s), .cfg_p(cfg_p), .cfg_q(cfg_q), .cfg_u(cfg_u), .cfg_v(cfg_v),
    .org_x(org_x), .org_y(org_y), .tile_h(tile_h), .tile_w(tile_w),
    .busy(busy), .done(done), .out_valid(out_valid), .out_row(out_row),
    .out_col(out_col), .out_addr(out_addr), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .pix_valid(pix_valid), .pix_row(pix_row),
    .pix_col(pix_col), .pix_data(pix_data)
  );

  function automatic logic [15:0] pix_of(input int a);
    return 16'(a * 40503) ^ 16'h5A5A;
  endfunction

  // Synchronous memory, one cycle of read latency.
  always @(posedge clk) if (mem_rd) mem_rdata <= pix_of(int'(mem_addr));

  int vectors = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int L_N, L_C, L_H, L_W, L_R, L_S, L_P, L_Q, L_U, L_V;

  int ob_row[$], ob_col[$], ob_addr[$], ob_cyc[$];
  int pb_row[$], pb_col[$], pb_dat[$];
  int done_cnt, done_cyc, done_clash;

  always @(negedge clk) begin
    if (out_valid) begin
      ob_row.push_back(int'(out_row)); ob_col.push_back(int'(out_col));
      ob_addr.push_back(int'(out_addr)); ob_cyc.push_back(cyc);
    end
    if (pix_valid) begin
      pb_row.push_back(int'(pix_row)); pb_col.push_back(int'(pix_col));
      pb_dat.push_back(int'(pix_data));
    end
    if (done) begin
      done_cnt++; done_cyc = cyc;
      if (out_valid) done_clash++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_addr(input int x, input int y);
    int c, r, s, n, p, q;
    c = x / (L_R * L_S); r = (x % (L_R * L_S)) / L_S; s = x % L_S;
    n = y / (L_P * L_Q); p = (y % (L_P * L_Q)) / L_Q; q = y % L_Q;
    return ((n * L_C + c) * L_H + p * L_U + r) * L_W + q * L_V + s;
  endfunction

  task automatic set_layer(input int n, input int c, input int h, input int w,
                           input int r, input int s, input int u, input int v);
    L_N = n; L_C = c; L_H = h; L_W = w; L_R = r; L_S = s; L_U = u; L_V = v;
    L_P = (h - r) / u + 1; L_Q = (w - s) / v + 1;
    cfg_n = DIM_W'(L_N); cfg_c = DIM_W'(L_C); cfg_h = DIM_W'(L_H); cfg_w = DIM_W'(L_W);
    cfg_r = DIM_W'(L_R); cfg_s = DIM_W'(L_S); cfg_p = DIM_W'(L_P); cfg_q = DIM_W'(L_Q);
    cfg_u = DIM_W'(L_U); cfg_v = DIM_W'(L_V);
  endtask

  task automatic run_tile(input int x0, input int y0, input int th, input int tw, input bit poke);
    int eh, ew, k, lim;
    int er[$], ec[$];
    bit seen;
    eh = (L_C * L_R * L_S - x0 < th) ? L_C * L_R * L_S - x0 : th;
    ew = (L_N * L_P * L_Q - y0 < tw) ? L_N * L_P * L_Q - y0 : tw;
    // R4: expected visiting order
    for (int sr = 0; sr < eh; sr += SUB)
      for (int sc = 0; sc < ew; sc += SUB)
        for (int i = sr; i < sr + SUB && i < eh; i++)
          for (int j = sc; j < sc + SUB && j < ew; j++) begin
            er.push_back(i); ec.push_back(j);
          end
    ob_row.delete(); ob_col.delete(); ob_addr.delete(); ob_cyc.delete();
    pb_row.delete(); pb_col.delete(); pb_dat.delete();
    done_cnt = 0; done_clash = 0; done_cyc = -1;
    @(negedge clk);
    org_x = IDX_W'(x0); org_y = IDX_W'(y0); tile_h = LEN_W'(th); tile_w = LEN_W'(tw);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      @(negedge clk);
      org_x = '0; org_y = '0; tile_h = LEN_W'(1); tile_w = LEN_W'(1);
      start = 1'b1;   // R8: must be ignored
      @(negedge clk);
      start = 1'b0;
    end
    seen = 1'b0;
    lim = 4000;
    while (!seen && lim > 0) begin
      @(negedge clk);
      if (done) seen = 1'b1;
      lim--;
    end
    check(seen, "R6 watchdog", 0, 1);
    repeat (2) @(negedge clk);
    // R3: count of beats
    check(ob_addr.size() == er.size(), "R3 beat count", ob_addr.size(), er.size());
    for (k = 0; k < er.size() && k < ob_addr.size(); k++) begin
      check(ob_row[k] == er[k] && ob_col[k] == ec[k], "R2,R4 position",
            ob_row[k] * 100 + ob_col[k], er[k] * 100 + ec[k]);
      check(ob_addr[k] == ref_addr(x0 + er[k], y0 + ec[k]), poke ? "R8 address" : "R1,R10 address",
            ob_addr[k], ref_addr(x0 + er[k], y0 + ec[k]));
      if (k > 0)
        check(ob_cyc[k] == ob_cyc[k-1] + 1, "R5 contiguous", ob_cyc[k], ob_cyc[k-1] + 1);
    end
    check(pb_dat.size() == er.size(), "R7 pixel count", pb_dat.size(), er.size());
    for (k = 0; k < er.size() && k < pb_dat.size(); k++) begin
      check(pb_dat[k] == int'(pix_of(ref_addr(x0 + er[k], y0 + ec[k]))), "R7 pixel",
            pb_dat[k], int'(pix_of(ref_addr(x0 + er[k], y0 + ec[k]))));
      check(pb_row[k] == er[k] && pb_col[k] == ec[k], "R7 pixel position",
            pb_row[k] * 100 + pb_col[k], er[k] * 100 + ec[k]);
    end
    check(done_cnt == 1 && done_clash == 0, "R6 single done", done_cnt, 1);
    if (ob_cyc.size() > 0)
      check(done_cyc == ob_cyc[ob_cyc.size()-1] + 1, "R6 done timing",
            done_cyc, ob_cyc[ob_cyc.size()-1] + 1);
  endtask

  initial begin
    int dummy;
    dummy = $urandom(2024);
    rst_n = 1'b0; start = 1'b0; org_x = '0; org_y = '0; tile_h = '0; tile_w = '0;
    set_layer(2, 2, 5, 6, 3, 2, 1, 2);   // P=3, Q=3, matrix 12 x 18
    repeat (3) @(negedge clk);
    // R9: reset state
    check(!busy && !done && !out_valid && !mem_rd && !pix_valid, "R9 reset outputs",
          {busy, done, out_valid, mem_rd, pix_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !out_valid, "R9 idle after reset", {busy, out_valid}, 0);

    run_tile(0, 0, 16, 16, 1'b0);    // R3: rows clipped to 12
    run_tile(5, 10, 16, 16, 1'b0);   // R3: clipped on both edges, partial sub-tiles
    run_tile(11, 17, 1, 1, 1'b0);    // R3: final element only
    run_tile(3, 4, 9, 7, 1'b1);      // R8: start pulse while busy
    set_layer(1, 3, 7, 7, 3, 3, 2, 2);
    run_tile(7, 2, 16, 16, 1'b0);    // R10: carries through s, r, c and q, p

    for (int t = 0; t < 40; t++) begin
      int h, w, r, s;
      h = $urandom_range(3, 7); w = $urandom_range(3, 7);
      r = $urandom_range(1, 3); s = $urandom_range(1, 3);
      set_layer($urandom_range(1, 2), $urandom_range(1, 3), h, w, r, s,
                $urandom_range(1, 2), $urandom_range(1, 2));
      run_tile($urandom_range(0, L_C * L_R * L_S - 1), $urandom_range(0, L_N * L_P * L_Q - 1),
               $urandom_range(1, TILE), $urandom_range(1, TILE), 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL global watchdog actual=%0d expected=%0d", cyc, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule